// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a synthesizable on-chip synchronous SRAM whose write data is delayed to line up with its read data. Because a write's data arrives as many clock edges after its command as a read's data leaves after its command, a shared data bus can carry any mix of reads and writes on consecutive cycles with no idle turnaround cycle. The word is split into byte lanes that are written individually. The default is four lanes of eight bits and sixteen words.

A mode input sets both latencies at once. In pipelined mode read data leaves through an output register and write data is taken two enabled edges after its command. In flow-through mode read data comes straight from the array after the command edge and write data is taken one enabled edge after its command. An active-low clock enable freezes the whole pipeline. Three chip selects qualify each new command. A load/advance control either starts a new access or continues the open one through a two-bit burst counter. Read data that targets a word whose write is still pending is merged with that write's bytes, so a read always sees the latest write.

Top module: `lw_sram`

## Requirements
- R1: When `ce_n` is high at a rising edge, no state changes at that edge. `rvalid` and `rdata` hold their values, and any pending read or write moves one cycle later.
- R2: The device is selected only when `sel0_n` is 0, `sel1` is 1 and `sel2_n` is 0. A load cycle (`load_n` = 0) that is not selected starts no read and no write, and it closes any open burst.
- R3: In pipelined mode (`flow_mode` = 0), a read loaded at enabled edge n drives `rvalid` = 1 and the word in `rdata` from edge n+1 until the next enabled edge.
- R4: In pipelined mode, a write loaded at enabled edge n takes its data from `wdata` at enabled edge n+2.
- R5: In flow-through mode (`flow_mode` = 1), a read loaded at enabled edge n drives `rvalid` = 1 and the word from just after edge n until the next enabled edge.
- R6: In flow-through mode, a write loaded at enabled edge n takes its data from `wdata` at enabled edge n+1.
- R7: `lane_wr_n[i]` = 0 writes lane i, bits 8i+7..8i of the word, from `wdata` bits 8i+7..8i. Lanes whose enable is 1 keep their contents. A write with all four enables at 1 changes nothing.
- R8: A cycle with `load_n` = 1 while a burst is open repeats the open access type at the next address. That address increments bits 1..0 by one, wraps within the aligned group of four, and leaves the upper bits unchanged. Byte enables are sampled fresh on every such cycle. With no burst open, the cycle does nothing.
- R9: In pipelined mode, a read loaded one enabled edge after a write to the same word returns the stored word with the lanes that write enables replaced by its data.
- R10: Whenever `rvalid` is 0, `rdata` is all zeros. After reset `rvalid` is 0.
- R11: Reads and writes, loaded or bursting, can be issued on every enabled edge in either mode, and every read returns the latest data written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| flow_mode | input | 1 | 1 selects flow-through latency, 0 selects pipelined latency; change only while idle |
| ce_n | input | 1 | Active-low clock enable for all internal state |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | 0 loads a write, 1 loads a read |
| load_n | input | 1 | 0 loads a new address and command, 1 advances the open burst |
| lane_wr_n | input | LANES | Active-low byte-lane write enables |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Late write data |
| rdata | output | LANES*LANE_W | Read data, zero when not valid |
| rvalid | output | 1 | High while `rdata` carries a read result |

## Verification
Every result is tied to a count of enabled clock edges. A pipelined read is due one enabled edge after its command. A flow-through read is due right after its command edge. Write data is driven on the bus for the enabled edge two edges (pipelined) or one edge (flow-through) after its command. The driver counts only edges with `ce_n` low. It places each read's expected word in a queue, tagged with the enabled edge at which it falls due, and it schedules each write's data for its due edge. A monitor samples at the falling edge. There it pops the entry due for the current edge count, checks that `rdata`/`rvalid` held still when no enabled edge occurred, and otherwise expects `rvalid` low with zero data.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
   // width of the linear burst counter (aligned group of 2**BURST_W words)
   localparam int BURST_W = 2;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;
endpackage

// File: rtl/lw_cmd_stage.sv
module lw_cmd_stage
   import lw_sram_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic              sel,
   input  logic              wr_n,
   input  logic              load_n,
   input  logic [LANES-1:0]  lane_wr_n,
   input  logic [ADDR_W-1:0] addr,
   output op_e               s1_op,
   output logic [ADDR_W-1:0] s1_addr,
   output logic [LANES-1:0]  s1_lanes
);
   logic              burst_open;
   op_e               burst_op;
   logic [ADDR_W-1:0] next_addr;

   // linear increment confined to the aligned group
   always_comb begin
      next_addr = s1_addr;
      next_addr[BURST_W-1:0] = s1_addr[BURST_W-1:0] + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_op      <= OP_IDLE;
         s1_addr    <= '0;
         s1_lanes   <= '0;
         burst_open <= 1'b0;
         burst_op   <= OP_IDLE;
      end else if (ce) begin
         s1_lanes <= ~lane_wr_n;
         if (!load_n) begin
            if (sel) begin
               s1_op      <= wr_n ? OP_READ : OP_WRITE;
               burst_op   <= wr_n ? OP_READ : OP_WRITE;
               s1_addr    <= addr;
               burst_open <= 1'b1;
            end else begin
               s1_op      <= OP_IDLE;
               burst_open <= 1'b0;
            end
         end else if (burst_open) begin
            s1_op   <= burst_op;
            s1_addr <= next_addr;
         end else begin
            s1_op <= OP_IDLE;
         end
      end
   end

   AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !load_n && !sel) |=> (s1_op == OP_IDLE)); // R2

   AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && load_n && burst_open) |=>
         (s1_addr[BURST_W-1:0] == BURST_W'($past(s1_addr[BURST_W-1:0]) + 1'b1))
         && (s1_op == $past(burst_op))); // R8
endmodule

// File: rtl/lw_byte_mem.sv
module lw_byte_mem #(
   parameter int ADDR_W = 4,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int DEPTH  = 1 << ADDR_W,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [LANES-1:0]  wlanes,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rword
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];

      always_ff @(posedge clk) begin
         if (we && wlanes[g]) store[waddr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rword[g*LANE_W +: LANE_W] = store[raddr];
   end
endmodule

// File: rtl/lw_write_pipe.sv
module lw_write_pipe
   import lw_sram_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic              flow,
   input  op_e               s1_op,
   input  logic [ADDR_W-1:0] s1_addr,
   input  logic [LANES-1:0]  s1_lanes,
   output logic              cm_valid,
   output logic [ADDR_W-1:0] cm_addr,
   output logic [LANES-1:0]  cm_lanes
);
   logic              s2_wr;
   logic [ADDR_W-1:0] s2_addr;
   logic [LANES-1:0]  s2_lanes;

   // second stage only matters for the double-late (pipelined) protocol
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_wr    <= 1'b0;
         s2_addr  <= '0;
         s2_lanes <= '0;
      end else if (ce) begin
         s2_wr    <= (s1_op == OP_WRITE);
         s2_addr  <= s1_addr;
         s2_lanes <= s1_lanes;
      end
   end

   always_comb begin
      if (flow) begin
         cm_valid = (s1_op == OP_WRITE);
         cm_addr  = s1_addr;
         cm_lanes = s1_lanes;
      end else begin
         cm_valid = s2_wr;
         cm_addr  = s2_addr;
         cm_lanes = s2_lanes;
      end
   end

   AST_PIPE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !flow && s1_op == OP_WRITE) |=>
         (cm_valid && cm_addr == $past(s1_addr))); // R4

   AST_FLOW_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (flow && s1_op == OP_WRITE) |-> cm_valid); // R6
endmodule

// File: rtl/lw_read_path.sv
module lw_read_path #(
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic              flow,
   input  logic              s1_rd,
   input  logic [DATA_W-1:0] mem_word,
   input  logic              fwd_hit,
   input  logic [LANES-1:0]  fwd_lanes,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);
   logic [DATA_W-1:0] merged;
   logic [DATA_W-1:0] out_d;
   logic              out_v;

   // late-write forwarding: lanes of the write landing this edge win
   for (genvar g = 0; g < LANES; g++) begin : g_merge
      assign merged[g*LANE_W +: LANE_W] = (fwd_hit && fwd_lanes[g]) ?
         wdata[g*LANE_W +: LANE_W] : mem_word[g*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_v <= 1'b0;
         out_d <= '0;
      end else if (ce) begin
         out_v <= s1_rd;
         out_d <= s1_rd ? merged : '0;
      end
   end

   assign rvalid = flow ? s1_rd : out_v;
   assign rdata  = !rvalid ? '0 : (flow ? mem_word : out_d);

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rvalid |-> (rdata == '0)); // R10

   AST_PIPE_READ_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !flow && s1_rd) |=> rvalid); // R3

   AST_FLOW_READ_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      (flow && s1_rd) |-> rvalid); // R5
endmodule

// File: rtl/lw_sram.sv
module lw_sram
   import lw_sram_pkg::*;
#(
   parameter int ADDR_W       = 4,
   parameter int LANES        = 4,
   parameter int LANE_W       = 8,
   parameter bit FLOW_CAPABLE = 1'b1,
   localparam int DATA_W       = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flow_mode,
   input  logic              ce_n,
   input  logic              sel0_n,
   input  logic              sel1,
   input  logic              sel2_n,
   input  logic              wr_n,
   input  logic              load_n,
   input  logic [LANES-1:0]  lane_wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);
   if (ADDR_W <= BURST_W) begin : g_bad_addr
      $error("lw_sram: ADDR_W must exceed the burst counter width");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("lw_sram: LANES and LANE_W must be positive");
   end

   logic ce, sel, flow;
   assign ce  = !ce_n;
   assign sel = !sel0_n && sel1 && !sel2_n;

   if (FLOW_CAPABLE) begin : g_flow
      assign flow = flow_mode;
   end else begin : g_pipe_only
      assign flow = 1'b0;
   end

   op_e               s1_op;
   logic [ADDR_W-1:0] s1_addr;
   logic [LANES-1:0]  s1_lanes;
   logic              cm_valid;
   logic [ADDR_W-1:0] cm_addr;
   logic [LANES-1:0]  cm_lanes;
   logic [DATA_W-1:0] mem_word;
   logic              fwd_hit;

   lw_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
      .clk(clk), .rst_n(rst_n), .ce(ce), .sel(sel), .wr_n(wr_n),
      .load_n(load_n), .lane_wr_n(lane_wr_n), .addr(addr),
      .s1_op(s1_op), .s1_addr(s1_addr), .s1_lanes(s1_lanes)
   );

   lw_write_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wpipe (
      .clk(clk), .rst_n(rst_n), .ce(ce), .flow(flow),
      .s1_op(s1_op), .s1_addr(s1_addr), .s1_lanes(s1_lanes),
      .cm_valid(cm_valid), .cm_addr(cm_addr), .cm_lanes(cm_lanes)
   );

   lw_byte_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
      .clk(clk), .we(ce && cm_valid), .waddr(cm_addr), .wlanes(cm_lanes),
      .wdata(wdata), .raddr(s1_addr), .rword(mem_word)
   );

   // only the pipelined protocol has a write still in flight when a read samples
   assign fwd_hit = !flow && cm_valid && (cm_addr == s1_addr);

   lw_read_path #(.LANES(LANES), .LANE_W(LANE_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .ce(ce), .flow(flow),
      .s1_rd(s1_op == OP_READ), .mem_word(mem_word),
      .fwd_hit(fwd_hit), .fwd_lanes(cm_lanes), .wdata(wdata),
      .rdata(rdata), .rvalid(rvalid)
   );

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> ($stable(rvalid) && $stable(rdata))); // R1
endmodule

// File: tb/lw_sram_test.sv
`timescale 1ns/1ps
module lw_sram_test;
   localparam int AW = 4, LN = 4, LW = 8, DW = 32, DEPTH = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic flow_mode = 1'b0, ce_n = 1'b1, sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
   logic wr_n = 1'b1, load_n = 1'b1;
   logic [LN-1:0] lane_wr_n = '1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic rvalid;

   lw_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) uut (
      .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .ce_n(ce_n),
      .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n), .wr_n(wr_n),
      .load_n(load_n), .lane_wr_n(lane_wr_n), .addr(addr), .wdata(wdata),
      .rdata(rdata), .rvalid(rvalid)
   );

   always #2 clk = ~clk;   // 250 MHz

   typedef struct { int due; logic [DW-1:0] data; string tag; } exp_t;
   typedef struct { logic [AW-1:0] a; logic [LN-1:0] lanes; } wcmd_t;

   exp_t          exp_q[$];
   logic [DW-1:0] ref_mem [DEPTH];
   logic [DW-1:0] wd_sched [int];
   wcmd_t         commit_at [int];
   logic [AW-1:0] rd_at [int];
   string         rd_tag_at [int];
   int  en_edges = 0, checks = 0, fails = 0;
   string cur_tag = "R11";
   bit  m_open = 0, m_wr = 0;
   logic [AW-1:0] m_addr = '0;
   bit  finished = 0;

   task automatic check(bit ok, string tag, logic [DW:0] act, logic [DW:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual {rvalid,rdata}=%h expected %h at edge %0d",
                  tag, act, exp, en_edges);
      end
   endtask

   // reference model of one enabled edge, driven from the requirements
   task automatic model_edge(bit ld, bit sel, bit wr, logic [LN-1:0] lanes_n, logic [AW-1:0] a);
      int n, op;
      en_edges++;
      n = en_edges;
      if (commit_at.exists(n)) begin
         for (int l = 0; l < LN; l++)
            if (commit_at[n].lanes[l])
               ref_mem[commit_at[n].a][l*LW +: LW] = wd_sched[n][l*LW +: LW];
         commit_at.delete(n);
         wd_sched.delete(n);
      end
      if (rd_at.exists(n)) begin
         exp_q.push_back('{n, ref_mem[rd_at[n]], rd_tag_at[n]});
         rd_at.delete(n);
         rd_tag_at.delete(n);
      end
      op = 0;
      if (ld) begin
         if (sel) begin
            op = wr ? 2 : 1; m_addr = a; m_open = 1; m_wr = wr;
         end else m_open = 0;
      end else if (m_open) begin
         m_addr[1:0] = m_addr[1:0] + 2'd1;
         op = m_wr ? 2 : 1;
      end
      if (op == 2) begin
         int lat;
         lat = flow_mode ? 1 : 2;
         commit_at[n+lat] = '{m_addr, ~lanes_n};
         wd_sched[n+lat]  = $urandom;
      end else if (op == 1) begin
         if (flow_mode) exp_q.push_back('{n, ref_mem[m_addr], cur_tag});
         else begin
            rd_at[n+1] = m_addr;
            rd_tag_at[n+1] = cur_tag;
         end
      end
   endtask

   // driver: ld=1 loads (load_n low), wr=1 is a write command
   task automatic step(bit ce, bit ld, bit sel, bit wr, logic [LN-1:0] lanes_n, logic [AW-1:0] a);
      ce_n = !ce; load_n = !ld; wr_n = !wr; lane_wr_n = lanes_n; addr = a;
      sel0_n = 1'b0; sel1 = 1'b1; sel2_n = 1'b0;
      if (!sel) begin
         case ($urandom % 3)
            0: sel0_n = 1'b1;
            1: sel1   = 1'b0;
            default: sel2_n = 1'b1;
         endcase
      end
      if (ce && wd_sched.exists(en_edges + 1)) wdata = wd_sched[en_edges + 1];
      else wdata = $urandom;
      @(posedge clk);
      #1;
      if (ce) model_edge(ld, sel, wr, lanes_n, a);
   endtask

   task automatic wr_word(logic [AW-1:0] a, logic [LN-1:0] lanes_n);
      step(1, 1, 1, 1, lanes_n, a);
   endtask
   task automatic rd_word(logic [AW-1:0] a);
      step(1, 1, 1, 0, '1, a);
   endtask
   task automatic advance(logic [LN-1:0] lanes_n);
      step(1, 0, 1, 0, lanes_n, '0);
   endtask
   task automatic drain();
      for (int i = 0; i < 3; i++) step(1, 1, 0, 0, '1, '0);
   endtask
   task automatic random_mix(int count, int stall_div);
      for (int i = 0; i < count; i++) begin
         logic [LN-1:0] ln;
         case ($urandom % 4)
            0: ln = '0;
            1: ln = '1;
            default: ln = LN'($urandom);
         endcase
         step(($urandom % stall_div) != 0, ($urandom % 4) != 0, ($urandom % 8) != 0,
              $urandom % 2, ln, AW'($urandom));
      end
   endtask

   // monitor: scoreboard pop and hold/idle checks at the falling edge
   int last_seen = 0;
   logic [DW-1:0] prev_d = '0;
   logic prev_v = 1'b0;
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (en_edges == last_seen) begin
            check(rvalid === prev_v && rdata === prev_d, "R1 stall hold",
                  {rvalid, rdata}, {prev_v, prev_d});
         end else if (exp_q.size() > 0 && exp_q[0].due == en_edges) begin
            exp_t e;
            e = exp_q.pop_front();
            check(rvalid === 1'b1 && rdata === e.data, e.tag,
                  {rvalid, rdata}, {1'b1, e.data});
         end else begin
            check(rvalid === 1'b0 && rdata === '0, "R10 idle output",
                  {rvalid, rdata}, {1'b0, {DW{1'b0}}});
         end
      end
      last_seen = en_edges;
      prev_v = rvalid;
      prev_d = rdata;
   end

   task automatic finish_up();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
      repeat (3) @(posedge clk);
      #1;
      check(rvalid === 1'b0 && rdata === '0, "R10 reset state",
            {rvalid, rdata}, {1'b0, {DW{1'b0}}});
      rst_n = 1'b1;

      // pipelined: fill the array back to back
      cur_tag = "R11";
      for (int a = 0; a < DEPTH; a++) wr_word(AW'(a), '0);
      drain();
      cur_tag = "R3";
      for (int a = 0; a < DEPTH; a++) rd_word(AW'(a));
      drain();
      cur_tag = "R4";
      wr_word(5, '0); rd_word(1); rd_word(5); drain();
      cur_tag = "R9";
      wr_word(9, 4'b1010); rd_word(9); drain();
      wr_word(10, 4'b0000); rd_word(10); rd_word(10); drain();
      cur_tag = "R7";
      wr_word(2, 4'b1110); wr_word(4, 4'b1111); wr_word(6, 4'b0101);
      rd_word(2); rd_word(4); rd_word(6); drain();
      cur_tag = "R2";
      step(1, 1, 0, 1, '0, 8); step(1, 1, 0, 0, '1, 8); rd_word(8); drain();
      cur_tag = "R8";
      rd_word(6);
      for (int i = 0; i < 5; i++) advance('1);
      wr_word(13, '0);
      for (int i = 0; i < 3; i++) advance(LN'($urandom));
      drain();
      for (int a = 12; a < 16; a++) rd_word(AW'(a));
      step(1, 1, 0, 0, '1, 0); advance('1); advance('1);
      drain();
      cur_tag = "R1";
      random_mix(300, 4);
      drain();
      cur_tag = "R11";
      random_mix(300, 50);
      drain();

      // flow-through
      flow_mode = 1'b1;
      cur_tag = "R5";
      for (int a = 0; a < 4; a++) rd_word(AW'(a));
      drain();
      cur_tag = "R6";
      wr_word(3, '0); rd_word(3); wr_word(4, 4'b0011); rd_word(4); drain();
      cur_tag = "R8";
      wr_word(7, '0); advance('0); advance('0); rd_word(4); advance('1);
      advance('1); advance('1); drain();
      cur_tag = "R11";
      random_mix(400, 5);
      drain();

      // back to pipelined traffic
      flow_mode = 1'b0;
      random_mix(400, 6);
      drain();
      check(exp_q.size() == 0, "R11 all reads returned",
            {1'b0, 32'(exp_q.size())}, '0);
      finish_up();
   end
endmodule